// File: doc/BRIEF.md
# Register-Mapped Serial Channel with Selectable Parity

This block is one asynchronous serial channel that a processor reaches through a small register window. It shares an address bus with its sibling channels. The channel answers only when the upper address bits match its own index plus a fixed base of 4 and the system chip select is low. A write strobe or a read strobe, both active low, then reaches one of four registers, picked by the two lowest address bits. The transmit register is write-only and sits at the same address as the receive register, which is read-only. The other registers are control/status and the two bytes of a 16-bit baud divisor.

The divisor sets a sampling enable that fires once every divisor+1 clocks. That rate is sixteen times the bit rate. A 4-bit prescaler takes every sixteenth of those enables to clock the transmitter. Both directions use the same frame: a low start bit, eight data bits least significant first, an optional parity slot, and one high stop bit. Mode 11 is the user mode. In this mode the parity slot carries a free user bit instead of a checked parity. The received value of that bit is reported in the status register.

The transmitter walks through the states TX_IDLE, TX_ARM, TX_START, TX_DATA, TX_PAR and TX_STOP:

- TX_IDLE to TX_ARM on a data write.
- TX_ARM to TX_START on the next bit enable.
- TX_START to TX_DATA after one bit.
- TX_DATA to TX_PAR, or to TX_STOP when the mode is none, after the eighth bit.
- TX_PAR to TX_STOP after one bit.
- TX_STOP to TX_IDLE after one bit.

The receiver walks through the states RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP:

- RX_IDLE to RX_START when the synchronised line is seen low on a sampling enable.
- RX_START back to RX_IDLE if the line is high at the eighth sample. Otherwise RX_START to RX_DATA.
- RX_DATA to RX_PAR, or to RX_STOP, after the eighth centre sample.
- RX_PAR to RX_STOP after one bit.
- RX_STOP to RX_IDLE at the stop-bit centre, where the byte is delivered.

Top module: `uart_chan`

## Requirements
- R1: After reset, which is asynchronous and active high, the outputs and registers hold these values:
  - `txd` is 1, `tx_irq` is 1 and `rx_irq` is 0.
  - The status register reads 0.
  - Both divisor bytes read 0.
  - The parity mode is 00.
- R2: A register access takes place only when `sys_cs_n` is 0 and `addr_i[5:2]` equals CHAN_IDX+4. In every other case `rdata` is 0 and writes change nothing.
- R3: The divisor is {register 3, register 2}, and both bytes read back as written. The sampling enable fires every divisor+1 clocks. One transmitted bit lasts exactly 16*(divisor+1) clocks.
- R4: A write to register 0 sends a frame on `txd`: start bit 0, eight data bits least significant first, the parity slot if the mode is not 00, then stop bit 1. The line idles high.
- R5: Writing register 1 sets the parity mode from bits [1:0] and the user bit from bit 2. The mode encodings are:
  - 00: no parity slot.
  - 01: even, where the slot is the XOR of the data.
  - 10: odd, where the slot is the inverted XOR.
  - 11: user, where the slot carries the user bit.
- R6: `tx_irq` is high exactly while the transmitter is idle. A data write while it is busy is ignored, and the frame in progress is unchanged.
- R7: The receiver starts on a low line and confirms the start at the eighth of sixteen samples. A low pulse shorter than half a bit delivers nothing.
- R8: A received byte reads at register 0. Status bit 0 and `rx_irq` rise at the stop-bit centre. The end of a register-0 read clears them.
- R9: In modes 01 and 10, a received parity slot that disagrees with the data sets the sticky status bit 3. The end of a status read clears it. Mode 11 never sets it.
- R10: Status bit 2 holds the last received parity-slot bit in modes 01, 10 and 11, and 0 in mode 00. Status bit 1 is the transmitter busy flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| sys_cs_n | input | 1 | System chip select, active low |
| addr_i | input | 6 | Shared address bus; [5:2] selects the channel, [1:0] the register |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 unless this channel is being read |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| tx_irq | output | 1 | Transmitter ready |
| rx_irq | output | 1 | Received byte available |

## Verification
The bench probes the address decode with the neighbouring channel's address and with the chip select high. A decoder that ignored either would overwrite the divisor or drive the data bus. It measures the low run of an all-zero frame and expects exactly nine bit periods. A prescaler of the wrong length, or an off-by-one reload, shows up in that count. It writes a second byte while a frame is in flight and checks that the first byte arrives intact. It also sends a short low glitch, bad parity in even mode, and arbitrary slot bits in user mode. A receiver that skipped start confirmation would then deliver a phantom byte. A receiver that checked parity in user mode, or never cleared the sticky error, would flag a wrong error state.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_USER = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_ARM, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    // Value of the parity slot for a given mode; ones_odd is the XOR of the data.
    function automatic logic par_expect(par_mode_e m, logic ones_odd, logic user);
        case (m)
            PAR_EVEN: return ones_odd;
            PAR_ODD:  return !ones_odd;
            PAR_USER: return user;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DIV_W    = 16,
    parameter int OVS_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             rx_tick_o,
    output logic             tx_tick_o
);
    logic [DIV_W-1:0]    cnt;
    logic [OVS_LOG2-1:0] pre;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt       <= '0;
            rx_tick_o <= 1'b0;
        end else if (cnt == '0) begin
            rx_tick_o <= 1'b1;
            cnt       <= div_i;
        end else begin
            rx_tick_o <= 1'b0;
            cnt       <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)            pre <= '0;
        else if (rx_tick_o) pre <= pre + 1'b1;
    end

    assign tx_tick_o = rx_tick_o && (pre == '1);

    // R3: with a non-zero divisor, enables never fire back to back
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
        rx_tick_o && ($past(div_i) != '0) |=> !rx_tick_o);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_chan_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  par_mode_e         mode_i,
    input  logic              user_i,
    output logic              txd_o,
    output logic              busy_o
);
    localparam int CNT_W = $clog2(DATA_W);

    tx_state_e         state, nxt;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  idx;
    logic              par_q;
    logic              last_bit;

    assign last_bit = (idx == CNT_W'(DATA_W - 1));

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= TX_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (load_i) nxt = TX_ARM;
            TX_ARM:   if (tick_i) nxt = TX_START;
            TX_START: if (tick_i) nxt = TX_DATA;
            TX_DATA:  if (tick_i && last_bit) nxt = (mode_i == PAR_NONE) ? TX_STOP : TX_PAR;
            TX_PAR:   if (tick_i) nxt = TX_STOP;
            TX_STOP:  if (tick_i) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            shreg <= '0;
            idx   <= '0;
            par_q <= 1'b0;
        end else if (state == TX_IDLE && load_i) begin
            shreg <= data_i;
            idx   <= '0;
            par_q <= par_expect(mode_i, ^data_i, user_i);
        end else if (state == TX_DATA && tick_i) begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            TX_START: txd_o = 1'b0;
            TX_DATA:  txd_o = shreg[0];
            TX_PAR:   txd_o = par_q;
            default:  txd_o = 1'b1;
        endcase
        busy_o = (state != TX_IDLE);
    end

    // R4: the line only moves in the cycle after a bit enable
    a_r4_txd_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(txd_o));
    // R6: a load while busy leaves the frame contents untouched
    a_r6_busy_load_ignored: assert property (@(posedge clk) disable iff (rst)
        busy_o && load_i && !tick_i |=> $stable(shreg) && $stable(par_q));

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_chan_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OVS_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  par_mode_e         mode_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              pbit_o,
    output logic              perr_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [OVS_LOG2-1:0] HALF = OVS_LOG2'((1 << (OVS_LOG2 - 1)) - 1);
    localparam logic [OVS_LOG2-1:0] FULL = '1;

    rx_state_e           state, nxt;
    logic                rxd_m, rxd_s;
    logic [OVS_LOG2-1:0] cnt;
    logic [CNT_W-1:0]    idx;
    logic [DATA_W-1:0]   shreg;
    logic                slot_q;
    logic                centre, last_bit;

    assign centre   = tick_i && (cnt == FULL);
    assign last_bit = (idx == CNT_W'(DATA_W - 1));

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd_i;
            rxd_s <= rxd_m;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= RX_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick_i && !rxd_s) nxt = RX_START;
            RX_START: if (tick_i && cnt == HALF) nxt = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (centre && last_bit) nxt = (mode_i == PAR_NONE) ? RX_STOP : RX_PAR;
            RX_PAR:   if (centre) nxt = RX_STOP;
            RX_STOP:  if (centre) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            slot_q <= 1'b0;
        end else begin
            if (tick_i) begin
                if (state == RX_IDLE || (state == RX_START && cnt == HALF)) cnt <= '0;
                else                                                        cnt <= cnt + 1'b1;
            end
            if (state == RX_IDLE) idx <= '0;
            if (state == RX_DATA && centre) begin
                shreg <= {rxd_s, shreg[DATA_W-1:1]};
                idx   <= idx + 1'b1;
            end
            if (state == RX_PAR && centre) slot_q <= rxd_s;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            done_o <= 1'b0;
            data_o <= '0;
            pbit_o <= 1'b0;
            perr_o <= 1'b0;
        end else if (state == RX_STOP && centre) begin
            done_o <= 1'b1;
            data_o <= shreg;
            pbit_o <= (mode_i == PAR_NONE) ? 1'b0 : slot_q;
            perr_o <= (mode_i == PAR_EVEN || mode_i == PAR_ODD) &&
                      (slot_q != par_expect(mode_i, ^shreg, 1'b0));
        end else begin
            done_o <= 1'b0;
            perr_o <= 1'b0;
        end
    end

    // R8: one delivery pulse per frame
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R9: user mode never reports a parity error
    a_r9_user_no_err: assert property (@(posedge clk) disable iff (rst)
        done_o && ($past(mode_i) == PAR_USER) |-> !perr_o);

endmodule

// File: rtl/uart_chan.sv
module uart_chan
    import uart_chan_pkg::*;
#(
    parameter int CHAN_IDX  = 0,
    parameter int CHAN_BASE = 4,
    parameter int ADDR_W    = 6,
    parameter int OVS_LOG2  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sys_cs_n,
    input  logic [5:0] addr_i,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       txd,
    input  logic       rxd,
    output logic       tx_irq,
    output logic       rx_irq
);
    localparam int DATA_W = 8;
    localparam int DIV_W  = 2 * DATA_W;
    localparam int REG_W  = 2;
    localparam int SEL_W  = ADDR_W - REG_W;
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(CHAN_IDX + CHAN_BASE);

    logic              sel, wr_n_q, rd_n_q, wr_go, rd_end;
    logic [REG_W-1:0]  reg_a;
    logic [DIV_W-1:0]  div_q;
    par_mode_e         mode_q;
    logic              user_q;
    logic [DATA_W-1:0] rx_data_q;
    logic              avail_q, pbit_q, perr_q;
    logic              rx_tick, tx_tick, tx_busy;
    logic              rx_done, rx_pbit, rx_perr;
    logic [DATA_W-1:0] rx_data;

    assign sel    = !sys_cs_n && (addr_i[ADDR_W-1:REG_W] == MY_SEL);
    assign reg_a  = addr_i[REG_W-1:0];
    assign wr_go  = sel && !wr_n && wr_n_q;
    assign rd_end = sel && rd_n && !rd_n_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            wr_n_q <= 1'b1;
            rd_n_q <= 1'b1;
        end else begin
            wr_n_q <= wr_n;
            rd_n_q <= rd_n;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            div_q  <= '0;
            mode_q <= PAR_NONE;
            user_q <= 1'b0;
        end else if (wr_go) begin
            unique case (reg_a)
                2'd1: begin
                    mode_q <= par_mode_e'(wdata[1:0]);
                    user_q <= wdata[2];
                end
                2'd2:    div_q[DATA_W-1:0]     <= wdata;
                2'd3:    div_q[DIV_W-1:DATA_W] <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rx_data_q <= '0;
            avail_q   <= 1'b0;
            pbit_q    <= 1'b0;
            perr_q    <= 1'b0;
        end else begin
            if (rx_done) begin
                rx_data_q <= rx_data;
                avail_q   <= 1'b1;
                pbit_q    <= rx_pbit;
            end else if (rd_end && reg_a == 2'd0) begin
                avail_q   <= 1'b0;
            end
            perr_q <= (perr_q && !(rd_end && reg_a == 2'd1)) || (rx_done && rx_perr);
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !rd_n) begin
            unique case (reg_a)
                2'd0: rdata = rx_data_q;
                2'd1: rdata = {4'b0, perr_q, pbit_q, tx_busy, avail_q};
                2'd2: rdata = div_q[DATA_W-1:0];
                2'd3: rdata = div_q[DIV_W-1:DATA_W];
                default: rdata = '0;
            endcase
        end
    end

    assign tx_irq = !tx_busy;
    assign rx_irq = avail_q;

    uart_baud #(.DIV_W(DIV_W), .OVS_LOG2(OVS_LOG2)) u_baud (
        .clk(clk), .rst(rst), .div_i(div_q),
        .rx_tick_o(rx_tick), .tx_tick_o(tx_tick)
    );

    uart_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst(rst), .tick_i(tx_tick),
        .load_i(wr_go && reg_a == 2'd0), .data_i(wdata),
        .mode_i(mode_q), .user_i(user_q),
        .txd_o(txd), .busy_o(tx_busy)
    );

    uart_rx #(.DATA_W(DATA_W), .OVS_LOG2(OVS_LOG2)) u_rx (
        .clk(clk), .rst(rst), .tick_i(rx_tick), .rxd_i(rxd), .mode_i(mode_q),
        .done_o(rx_done), .data_o(rx_data), .pbit_o(rx_pbit), .perr_o(rx_perr)
    );

    // R2: no register changes unless the channel is selected
    a_r2_quiet_unselected: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(div_q) && $stable(mode_q) && $stable(user_q));
    // R8: a delivered byte raises the receive interrupt
    a_r8_irq_on_done: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> rx_irq);
    // R9: a status read with no frame landing clears the sticky error
    a_r9_err_cleared: assert property (@(posedge clk) disable iff (rst)
        rd_end && reg_a == 2'd1 && !rx_done |=> !perr_q);

endmodule

// File: tb/uart_chan_test.sv
module uart_chan_test;

    localparam logic [5:0] BASE  = 6'h10;
    localparam logic [5:0] OTHER = 6'h14;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sys_cs_n = 1'b1;
    logic [5:0] addr_i = '0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       txd;
    logic       rxd = 1'b1;
    logic       tx_irq, rx_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_chan uut (
        .clk(clk), .rst(rst), .sys_cs_n(sys_cs_n), .addr_i(addr_i),
        .wr_n(wr_n), .rd_n(rd_n), .wdata(wdata), .rdata(rdata),
        .txd(txd), .rxd(rxd), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_par(input int mode, input logic [7:0] d, input logic u);
        case (mode)
            1: return ^d;
            2: return ~^d;
            3: return u;
            default: return 1'b0;
        endcase
    endfunction

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d, input logic csn);
        @(negedge clk);
        addr_i = a; wdata = d; sys_cs_n = csn; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        sys_cs_n = 1'b1;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic csn, output logic [7:0] d);
        @(negedge clk);
        addr_i = a; sys_cs_n = csn; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        d = rdata;
        rd_n = 1'b1;
        @(negedge clk);
        sys_cs_n = 1'b1;
    endtask

    task automatic set_div(input int dv);
        bus_write(BASE + 6'd2, 8'(dv), 1'b0);
        bus_write(BASE + 6'd3, 8'(dv >> 8), 1'b0);
    endtask

    task automatic tx_grab(input int p, input bit wp, output logic [7:0] d,
                           output logic pb, output logic stp, output logic st_ok);
        int guard = 0;
        while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
        repeat (p / 2) @(negedge clk);
        st_ok = (txd === 1'b0);
        for (int i = 0; i < 8; i++) begin repeat (p) @(negedge clk); d[i] = txd; end
        pb = 1'b0;
        if (wp) begin repeat (p) @(negedge clk); pb = txd; end
        repeat (p) @(negedge clk);
        stp = txd;
        guard = 0;
        while (tx_irq !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    endtask

    task automatic rx_send(input int p, input logic [7:0] d, input bit wp, input logic pb);
        @(negedge clk);
        rxd = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (p) @(negedge clk); end
        if (wp) begin rxd = pb; repeat (p) @(negedge clk); end
        rxd = 1'b1;
        repeat (2 * p) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] got;
        logic       pb, stp, st_ok;
        int         p, cnt;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "txd", txd, 1);
        chk("R1", "tx_irq", tx_irq, 1);
        chk("R1", "rx_irq", rx_irq, 0);
        bus_read(BASE + 6'd1, 1'b0, rd); chk("R1", "status", rd, 0);
        bus_read(BASE + 6'd2, 1'b0, rd); chk("R1", "div lo", rd, 0);
        bus_read(BASE + 6'd3, 1'b0, rd); chk("R1", "div hi", rd, 0);

        // R2 decode
        bus_write(OTHER + 6'd2, 8'h55, 1'b0);
        bus_read(BASE + 6'd2, 1'b0, rd); chk("R2", "other channel write ignored", rd, 0);
        bus_write(BASE + 6'd3, 8'h77, 1'b1);
        bus_read(BASE + 6'd3, 1'b0, rd); chk("R2", "deselected write ignored", rd, 0);
        bus_write(BASE + 6'd2, 8'h03, 1'b0);
        bus_read(BASE + 6'd2, 1'b1, rd); chk("R2", "rdata with cs high", rd, 0);
        bus_read(OTHER + 6'd2, 1'b0, rd); chk("R2", "rdata other channel", rd, 0);
        bus_read(BASE + 6'd2, 1'b0, rd); chk("R3", "div lo readback", rd, 8'h03);

        // R3 bit period: all-zero frame, no parity, low run = 9 bits
        p = 64;
        bus_write(BASE + 6'd1, 8'h00, 1'b0);
        bus_write(BASE + 6'd0, 8'h00, 1'b0);
        cnt = 0;
        while (txd !== 1'b0 && cnt < 20000) begin @(negedge clk); cnt++; end
        cnt = 0;
        while (txd === 1'b0 && cnt < 20000) begin @(negedge clk); cnt++; end
        chk("R3", "low run clocks", cnt, 9 * p);
        repeat (2 * p) @(negedge clk);
        chk("R4", "idle high after frame", txd, 1);

        // R6 write while busy is ignored
        bus_write(BASE + 6'd1, 8'h01, 1'b0);
        bus_write(BASE + 6'd0, 8'hA5, 1'b0);
        chk("R6", "tx_irq low when busy", tx_irq, 0);
        bus_read(BASE + 6'd1, 1'b0, rd); chk("R10", "busy status bit", rd[1], 1);
        bus_write(BASE + 6'd0, 8'h3C, 1'b0);
        tx_grab(p, 1'b1, got, pb, stp, st_ok);
        chk("R6", "first byte kept", got, 8'hA5);
        chk("R5", "even parity slot", pb, exp_par(1, 8'hA5, 1'b0));
        chk("R6", "tx_irq back high", tx_irq, 1);
        cnt = 0;
        for (int i = 0; i < 3 * p; i++) begin @(negedge clk); if (txd !== 1'b1) cnt++; end
        chk("R6", "no second frame", cnt, 0);

        // R4/R5 random transmit frames
        for (int k = 0; k < 6; k++) begin
            logic [7:0] d;
            int         m, dv;
            logic       u;
            d  = 8'($urandom);
            m  = (k < 4) ? k : int'($urandom % 4);
            u  = 1'($urandom);
            dv = 1 + int'($urandom % 3);
            p  = 16 * (dv + 1);
            set_div(dv);
            bus_write(BASE + 6'd1, {5'b0, u, 2'(m)}, 1'b0);
            bus_write(BASE + 6'd0, d, 1'b0);
            tx_grab(p, m != 0, got, pb, stp, st_ok);
            chk("R4", "start bit", st_ok, 1);
            chk("R4", "data bits", got, d);
            chk("R5", "parity slot", pb, exp_par(m, d, u));
            chk("R4", "stop bit", stp, 1);
        end

        // R8/R10 random receive frames
        for (int k = 0; k < 6; k++) begin
            logic [7:0] d;
            int         m, dv;
            logic       u, slot;
            d  = 8'($urandom);
            m  = (k < 4) ? k : int'($urandom % 4);
            u  = 1'($urandom);
            dv = 1 + int'($urandom % 3);
            p  = 16 * (dv + 1);
            slot = exp_par(m, d, u);
            set_div(dv);
            bus_write(BASE + 6'd1, {5'b0, u, 2'(m)}, 1'b0);
            rx_send(p, d, m != 0, slot);
            chk("R8", "rx_irq set", rx_irq, 1);
            bus_read(BASE + 6'd1, 1'b0, rd);
            chk("R10", "status after frame", rd, {4'b0, 1'b0, (m != 0) ? slot : 1'b0, 1'b0, 1'b1});
            bus_read(BASE + 6'd0, 1'b0, rd);
            chk("R8", "received byte", rd, d);
            chk("R8", "rx_irq cleared by read", rx_irq, 0);
        end

        // R9 parity error, sticky, cleared by status read
        set_div(1); p = 32;
        bus_write(BASE + 6'd1, 8'h01, 1'b0);
        rx_send(p, 8'h5A, 1'b1, ~exp_par(1, 8'h5A, 1'b0));
        bus_read(BASE + 6'd1, 1'b0, rd); chk("R9", "error set", rd[3], 1);
        bus_read(BASE + 6'd1, 1'b0, rd); chk("R9", "error cleared", rd[3], 0);
        bus_write(BASE + 6'd1, 8'h02, 1'b0);
        rx_send(p, 8'h0F, 1'b1, ~exp_par(2, 8'h0F, 1'b0));
        bus_read(BASE + 6'd1, 1'b0, rd); chk("R9", "odd mismatch", rd[3], 1);
        bus_write(BASE + 6'd1, 8'h03, 1'b0);
        rx_send(p, 8'hF0, 1'b1, 1'b1);
        bus_read(BASE + 6'd1, 1'b0, rd);
        chk("R9", "no check in user mode", rd[3], 0);
        chk("R10", "user slot captured", rd[2], 1);
        bus_read(BASE + 6'd0, 1'b0, rd);

        // R7 short glitch rejected, then a real frame
        @(negedge clk); rxd = 1'b0;
        repeat (p / 4) @(negedge clk); rxd = 1'b1;
        repeat (4 * p) @(negedge clk);
        chk("R7", "glitch gives no byte", rx_irq, 0);
        bus_write(BASE + 6'd1, 8'h00, 1'b0);
        rx_send(p, 8'hC3, 1'b0, 1'b0);
        bus_read(BASE + 6'd0, 1'b0, rd);
        chk("R7", "frame after glitch", rd, 8'hC3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule